// File: doc/BRIEF.md
# Exhaustive Pattern Generator with Zero-State Insertion

This block produces test patterns for a small combinational circuit under test. It is a shift register with linear XOR feedback and one extra gate. That gate notices when every stage except the one about to be shifted out holds zero. It flips the feedback bit in exactly two states. The effect is to place the all-zero word between a chosen pair of consecutive states of the maximal-length sequence. A register of WIDTH stages therefore walks through all 2^WIDTH words once per period, and no word is repeated.

Three things are fixed by parameters: the feedback polynomial, the placement of the XOR gates, and the side from which the all-zero word is entered. The first placement puts the XOR gates on the external feedback path. The second puts them between stages. The entry side is either after the word with only the lowest bit set, or after the word with only the highest bit set. At run time, a mode input can switch the zero gate off to give the plain linear sequence. A load port sets the register to any start word, and that word becomes the reference for the end-of-period flag. The flag marks each return of the register to that word.

Top module: `exh_pattern_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `pattern` becomes 0001 (value 1) and `period_end` becomes 0. The stored reference word becomes 0001 as well.
- R2: Default configuration, with `linear_mode`=0 and `en`=1: the polynomial mask `POLY`, where bit j is the coefficient of x^j, is 5'b10011 (1+x+x^4). XOR gates sit on the external path and entry is after the low word. In this configuration the next pattern is {s[0]^s[1]^z, s[3:1]}, where z=1 exactly when s[3:1]=000. The period is 16, and every 4-bit value occurs exactly once in it.
- R3: In complete mode, 0000 follows 0001 directly when entry is after the low word. It follows 1000 directly when entry is after the high word; that sequence is the bit mirror of the R2 sequence. The register never stays at 0000.
- R4: With the XOR gates between stages and the default polynomial, the period is also 16 with every value once. The sequence runs 0001, 0000, 1001.
- R5: When `linear_mode`=1 the zero gate is off. From 0001, the default polynomial gives the 15 nonzero values and never 0000, with period 15.
- R6: With `POLY`=5'b10101 (1+x^2+x^4) and `linear_mode`=1, the register returns to 0001 after 6 steps.
- R7: While `en`=0 and `load`=0, `pattern` holds and `period_end` is 0.
- R8: When `load`=1, `seed` appears on `pattern` after the next edge, whatever the value of `en`. This includes 0000. Stepping continues from the loaded word.
- R9: `period_end` is 1 for the one cycle after an enabled step that makes `pattern` equal to the reference word. The reference word is the last loaded `seed`, or 0001 after reset.
- R10: If `load` is high on the edge where a step would have returned to the reference word, the load wins. `pattern` takes the new seed and `period_end` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the sequence by one step |
| load | input | 1 | Load `seed` into the register and the reference word |
| seed | input | WIDTH | Start word |
| linear_mode | input | 1 | 1 switches off the zero-insertion gate |
| pattern | output | WIDTH | Current test pattern |
| period_end | output | 1 | One-cycle mark on return to the reference word |

## Verification
The stepping path and the load path can both act on the same edge. The R10 case is a return to the reference word that lands on that edge. The bench creates it by loading 0000, stepping 31 times so that the next step would come back to 0000, and asserting `load` with a new seed on that edge. It then checks that the new seed is taken with no flag, and that the next flag comes exactly 16 steps later at the new word. Random stimulus also mixes `load` with `en` and `linear_mode` changes. Every cycle is judged against a bench model of the sequence and of the flag.

// File: rtl/exh_pattern_pkg.sv
package exh_pattern_pkg;

    // Placement of the XOR gates in the feedback network
    typedef enum logic {
        FB_EXTERNAL = 1'b0,
        FB_INTERNAL = 1'b1
    } fb_topo_e;

    // Side from which the inserted all-zero word is entered
    typedef enum logic {
        ZERO_AFTER_LSB = 1'b0,
        ZERO_AFTER_MSB = 1'b1
    } zero_entry_e;

    // Action applied to the register on the coming edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } step_act_e;

    // Load has priority over stepping
    function automatic step_act_e pick_action(input logic load, input logic en);
        if (load) begin
            return ACT_LOAD;
        end
        if (en) begin
            return ACT_STEP;
        end
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/exh_step.sv
module exh_step
    import exh_pattern_pkg::*;
#(
    parameter int              WIDTH = 4,
    parameter logic [WIDTH:0]  POLY  = 5'b10011,
    parameter fb_topo_e        TOPO  = FB_EXTERNAL,
    parameter zero_entry_e     ENTRY = ZERO_AFTER_LSB
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             linear,
    output logic [WIDTH-1:0] nxt
);

    // Canonical view: shifting toward bit 0, zero entered after word 1
    logic [WIDTH-1:0] canon;
    logic [WIDTH-1:0] canon_nxt;
    logic             zero_hit;
    logic             inject;

    for (genvar i = 0; i < WIDTH; i++) begin : g_map
        if (ENTRY == ZERO_AFTER_MSB) begin : g_rev
            assign canon[i] = cur[WIDTH-1-i];
            assign nxt[i]   = canon_nxt[WIDTH-1-i];
        end else begin : g_str
            assign canon[i] = cur[i];
            assign nxt[i]   = canon_nxt[i];
        end
    end

    // Detector over every stage except the one leaving the register
    assign zero_hit = ~|canon[WIDTH-1:1];
    assign inject   = zero_hit & ~linear;

    if (TOPO == FB_EXTERNAL) begin : g_ext
        logic lin_bit;
        assign lin_bit   = ^(canon & POLY[WIDTH-1:0]);
        assign canon_nxt = {lin_bit ^ inject, canon[WIDTH-1:1]};
    end else begin : g_int
        logic fb_bit;
        assign fb_bit             = canon[0] ^ inject;
        assign canon_nxt[WIDTH-1] = fb_bit;
        for (genvar i = 0; i < WIDTH-1; i++) begin : g_tap
            assign canon_nxt[i] = canon[i+1] ^ (POLY[i+1] & fb_bit);
        end
    end

endmodule

// File: rtl/exh_seed_track.sv
module exh_seed_track
    import exh_pattern_pkg::*;
#(
    parameter int                WIDTH     = 4,
    parameter logic [WIDTH-1:0]  RESET_PAT = 4'b0001
) (
    input  logic             clk,
    input  logic             rst,
    input  step_act_e        act,
    input  logic [WIDTH-1:0] seed_in,
    input  logic [WIDTH-1:0] stepped_val,
    output logic             period_end
);

    logic [WIDTH-1:0] ref_q;
    logic             mark_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= RESET_PAT;
            mark_q <= 1'b0;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    ref_q  <= seed_in;
                    mark_q <= 1'b0;
                end
                ACT_STEP: mark_q <= (stepped_val == ref_q);
                default:  mark_q <= 1'b0;
            endcase
        end
    end

    assign period_end = mark_q;

endmodule

// File: rtl/exh_pattern_gen.sv
module exh_pattern_gen
    import exh_pattern_pkg::*;
#(
    parameter int              WIDTH = 4,
    parameter logic [WIDTH:0]  POLY  = 5'b10011,
    parameter fb_topo_e        TOPO  = FB_EXTERNAL,
    parameter zero_entry_e     ENTRY = ZERO_AFTER_LSB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [WIDTH-1:0] seed,
    input  logic             linear_mode,
    output logic [WIDTH-1:0] pattern,
    output logic             period_end
);

    localparam logic [WIDTH-1:0] RESET_PAT = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_nxt;
    step_act_e        act;

    assign act = pick_action(load, en);

    exh_step #(
        .WIDTH (WIDTH),
        .POLY  (POLY),
        .TOPO  (TOPO),
        .ENTRY (ENTRY)
    ) u_step (
        .cur    (state_q),
        .linear (linear_mode),
        .nxt    (state_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RESET_PAT;
        end else begin
            unique case (act)
                ACT_LOAD: state_q <= seed;
                ACT_STEP: state_q <= state_nxt;
                default:  state_q <= state_q;
            endcase
        end
    end

    exh_seed_track #(
        .WIDTH     (WIDTH),
        .RESET_PAT (RESET_PAT)
    ) u_track (
        .clk         (clk),
        .rst         (rst),
        .act         (act),
        .seed_in     (seed),
        .stepped_val (state_nxt),
        .period_end  (period_end)
    );

    assign pattern = state_q;

endmodule

// File: rtl/exh_pattern_chk.sv
module exh_pattern_chk
    import exh_pattern_pkg::*;
#(
    parameter int          WIDTH = 4,
    parameter zero_entry_e ENTRY = ZERO_AFTER_LSB
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             load,
    input logic [WIDTH-1:0] seed,
    input logic             linear_mode,
    input logic [WIDTH-1:0] pattern,
    input logic             period_end
);

    localparam logic [WIDTH-1:0] ONE_PAT  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] PRE_ZERO = (ENTRY == ZERO_AFTER_LSB) ? ONE_PAT : (ONE_PAT << (WIDTH-1));

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (pattern == ONE_PAT && !period_end));

    assert_zero_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && en && !linear_mode && pattern == PRE_ZERO) |=> pattern == '0);

    assert_no_lockup_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && en && !linear_mode && pattern == '0) |=> pattern != '0);

    assert_linear_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && en && linear_mode && pattern != '0) |=> pattern != '0);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && !en) |=> (pattern == $past(pattern) && !period_end));

    assert_load_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> (pattern == $past(seed) && !period_end));

    assert_flag_cause_R9: assert property (@(posedge clk) disable iff (rst)
        period_end |-> ($past(en) && !$past(load)));

endmodule

bind exh_pattern_gen exh_pattern_chk #(
    .WIDTH (WIDTH),
    .ENTRY (ENTRY)
) u_exh_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .load        (load),
    .seed        (seed),
    .linear_mode (linear_mode),
    .pattern     (pattern),
    .period_end  (period_end)
);

// File: tb/test_exh_pattern_gen.sv
`timescale 1ns/1ps
module test_exh_pattern_gen;
    import exh_pattern_pkg::*;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         load = 1'b0;
    logic         linear_mode = 1'b0;
    logic [W-1:0] seed = '0;

    logic [W-1:0] pat_a, pat_i, pat_m, pat_s;
    logic         end_a, end_i, end_m, end_s;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    // bench model state: default instance, mirrored instance, reference word
    logic [W-1:0] ma, mm, mref;

    always #4 clk = ~clk;

    exh_pattern_gen i_exh_pattern_gen (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
        .linear_mode(linear_mode), .pattern(pat_a), .period_end(end_a));

    exh_pattern_gen #(.TOPO(FB_INTERNAL)) i_exh_pattern_gen_int (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
        .linear_mode(linear_mode), .pattern(pat_i), .period_end(end_i));

    exh_pattern_gen #(.ENTRY(ZERO_AFTER_MSB)) i_exh_pattern_gen_mir (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
        .linear_mode(linear_mode), .pattern(pat_m), .period_end(end_m));

    exh_pattern_gen #(.POLY(5'b10101)) i_exh_pattern_gen_sq (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
        .linear_mode(linear_mode), .pattern(pat_s), .period_end(end_s));

    function automatic logic [W-1:0] rev_bits(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    // R2 recurrence: new top bit s0^s1, plus the zero gate in complete mode
    function automatic logic [W-1:0] ref_next(input logic [W-1:0] s, input logic lin);
        logic z;
        z = (s[W-1:1] == '0) && !lin;
        return {s[0] ^ s[1] ^ z, s[W-1:1]};
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // apply current inputs for one edge and compare both modelled instances
    task automatic tick(input string tag);
        logic [W-1:0] na, nm;
        logic         ea, em;
        na = ma; nm = mm; ea = 1'b0; em = 1'b0;
        if (load) begin
            na = seed; nm = seed;
        end else if (en) begin
            na = ref_next(ma, linear_mode);
            nm = rev_bits(ref_next(rev_bits(mm), linear_mode));
            ea = (na == mref);
            em = (nm == mref);
        end
        if (load) mref = seed;
        cyc();
        chk({tag, " pattern"}, pat_a, na);
        chk1({tag, " period_end"}, end_a, ea);
        chk({tag, " mirrored pattern"}, pat_m, nm);
        chk1({tag, " mirrored period_end"}, end_m, em);
        ma = na; mm = nm;
    endtask

    task automatic do_reset();
        rst = 1'b1; en = 1'b0; load = 1'b0;
        cyc();
        cyc();
        rst = 1'b0;
        ma = 4'b0001; mm = 4'b0001; mref = 4'b0001;
    endtask

    initial begin
        int cnt_a[16];
        int cnt_i[16];
        int cnt_m[16];
        logic [W-1:0] prev_i, prev_m;

        void'($urandom(32'h5eed_0c4d));
        do_reset();
        // R1 reset state on every variant
        chk("R1 reset pattern", pat_a, 4'b0001);
        chk1("R1 reset period_end", end_a, 1'b0);
        chk("R1 reset pattern internal", pat_i, 4'b0001);
        chk("R1 reset pattern mirrored", pat_m, 4'b0001);

        // R2 R3 R4: one full complete-mode period
        for (int v = 0; v < 16; v++) begin
            cnt_a[v] = 0; cnt_i[v] = 0; cnt_m[v] = 0;
        end
        en = 1'b1; linear_mode = 1'b0;
        for (int k = 1; k <= 16; k++) begin
            prev_i = pat_i; prev_m = pat_m;
            tick("R2");
            cnt_a[pat_a]++; cnt_i[pat_i]++; cnt_m[pat_m]++;
            if (prev_i == 4'b0001) chk("R4 internal zero entry", pat_i, 4'b0000);
            if (prev_i == 4'b0000) chk("R4 internal after zero", pat_i, 4'b1001);
            if (prev_m == 4'b1000) chk("R3 mirrored zero entry", pat_m, 4'b0000);
            chk1("R4 internal period_end", end_i, k == 16);
        end
        for (int v = 0; v < 16; v++) begin
            chk_int("R2 value count per period", cnt_a[v], 1);
            chk_int("R4 internal value count per period", cnt_i[v], 1);
            chk_int("R3 mirrored value count per period", cnt_m[v], 1);
        end

        // R5 R6: linear mode
        do_reset();
        linear_mode = 1'b1; en = 1'b1;
        for (int k = 1; k <= 15; k++) begin
            tick("R5");
            chk1("R5 linear never zero", pat_a == '0, 1'b0);
            chk1("R6 short cycle period_end", end_s, (k % 6) == 0);
            if (k == 6) chk("R6 short cycle return", pat_s, 4'b0001);
        end

        // R7: hold
        en = 1'b0;
        for (int k = 0; k < 4; k++) tick("R7");

        // R8 R9: load all-zero seed in complete mode, then one period
        linear_mode = 1'b0;
        load = 1'b1; seed = 4'b0000;
        tick("R8");
        load = 1'b0; en = 1'b1;
        for (int k = 1; k <= 16; k++) tick("R8");
        chk1("R9 flag on return to loaded zero", end_a, 1'b1);

        // R10: load on the edge of a return
        for (int k = 1; k <= 15; k++) tick("R9");
        load = 1'b1; seed = 4'b0101;
        tick("R10");
        chk1("R10 load wins over return", end_a, 1'b0);
        chk("R10 new seed taken", pat_a, 4'b0101);
        load = 1'b0;
        for (int k = 1; k <= 16; k++) tick("R10");
        chk1("R10 flag after full period", end_a, 1'b1);
        chk("R10 back at new seed", pat_a, 4'b0101);

        // mixed random stimulus
        for (int k = 0; k < 3000; k++) begin
            en   = ($urandom % 4) != 0;
            load = ($urandom % 20) == 0;
            seed = W'($urandom);
            if (($urandom % 50) == 0) linear_mode = ~linear_mode;
            tick("R8 R9 random");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule